// File: doc/BRIEF.md
# Satellite Feed Supply Control Register Slave

This block is the two-wire serial control port of a satellite antenna feed supply. A host addresses it on an I2C bus and writes single bytes. The top three bits of each byte pick one of four 8-bit system registers, and the low five bits hold that register's payload. No separate pointer byte is sent, so one write transfer can update several registers one after another. A read returns the live fault flags, repeated for as long as the host acknowledges.

The decoded control bits go straight to the analog side. They are: supply enable, the two voltage choice bits, continuous tone, external modulation mode, detector threshold, dynamic current limiting, software voltage selection and a two-bit current limit. The block also turns the voltage bits and a range select pin into a two-bit output level code.

While the power-good input is low, the registers are held at zero and the port stays silent. While the over-temperature flag is high, the registers are held at zero.

Top module: `lnb_ctrl_i2c_slave`

## Requirements
- R1: The slave answers only the 7-bit address {0,0,0,1,0,addr_sel[1],addr_sel[0]}. It acknowledges the address byte by pulling SDA low (sda_oe=1) during the ninth clock. It lets any other address pass with no acknowledge and no register change, and it changes its SDA drive only while SCL is low.
- R2: In each written data byte, bits 7:5 select the target register: 001 is tone, 010 is command and 011 is control. Bits 4:0 are that register's payload. Every data byte is acknowledged.
- R3: A tone write sets tone_en from bit 4, mod_sel from bit 3 and the threshold bit from bit 2.
- R4: A command write sets dyn_lim from bit 4, sw_vsel from bit 3 and i_sel from bits 1:0 (bit 1 is the high bit).
- R5: A control write sets out_en from bit 4, v_top from bit 1 and v_bot from bit 0.
- R6: A data byte whose select field is 000 (status) or 1xx is acknowledged and changes no output.
- R7: Several data bytes in one write transfer are each applied to their own register, in order.
- R8: A read returns the byte {3'b000, stat_flags}, MSB first. The flag order is: bit 4 over-temperature, bit 3 cable fault, bit 2 voltage out of window, bit 1 overload, bit 0 back current. The slave sends a further byte after each master ACK and releases SDA after a NACK.
- R9: While pwr_good is low, all register outputs are zero from the next clock on, and the slave acknowledges nothing.
- R10: While stat_flags[4] is high, all register outputs are zero from the next clock on, and writes have no effect.
- R11: vlevel codes 0/1/2/3 stand for 13.3/14.3/18.3/19.3 V. With sw_vsel=1 the level is {v_top,v_bot}. With sw_vsel=0 and sel_hi_pin=0 it is 13.3 V or 14.3 V by v_bot. With sw_vsel=0 and sel_hi_pin=1 it is 18.3 V or 19.3 V by v_top.
- R12: thr_eff is high when the threshold register bit or tx_thr_pin is high.
- R13: After reset all register outputs and sda_oe are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_sel | input | 2 | Low two bits of the slave address |
| pwr_good | input | 1 | Supply valid; low clears and silences |
| stat_flags | input | 5 | Fault flags, bit 4 over-temperature down to bit 0 back current |
| tx_thr_pin | input | 1 | Transmit threshold request pin |
| sel_hi_pin | input | 1 | High voltage range select pin |
| out_en | output | 1 | Supply enable |
| v_top | output | 1 | High-range step bit |
| v_bot | output | 1 | Low-range step bit |
| tone_en | output | 1 | Continuous tone enable |
| mod_sel | output | 1 | External modulated input select |
| thr_eff | output | 1 | Effective detector threshold select |
| dyn_lim | output | 1 | Dynamic current limiting select |
| sw_vsel | output | 1 | Register-only voltage selection |
| i_sel | output | 2 | Current limit select |
| vlevel | output | 2 | Resolved output voltage code |

## Verification
Writes are sent as multi-byte transfers that mix all three writable selects. These show whether the select field routes each payload to the correct register and whether later bytes in a transfer are still applied. A foreign address, a status-select byte and a 1xx byte tell an ignored byte apart from a misrouted one. Reads with an ACK followed by a NACK show the byte repeat and the release of SDA. The voltage pin is toggled under both selection modes, and power-good loss and over-temperature are applied after the registers hold non-zero values, so that clearing can be seen against the earlier contents.

// File: rtl/lnb_ctrl_i2c_slave.sv
`timescale 1ns/1ps
module lnb_ctrl_i2c_slave #(
  parameter logic [4:0] DEV_HI   = 5'b00010,
  parameter int         SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_sel,
  input  logic       pwr_good,
  input  logic [4:0] stat_flags,
  input  logic       tx_thr_pin,
  input  logic       sel_hi_pin,
  output logic       out_en,
  output logic       v_top,
  output logic       v_bot,
  output logic       tone_en,
  output logic       mod_sel,
  output logic       thr_eff,
  output logic       dyn_lim,
  output logic       sw_vsel,
  output logic [1:0] i_sel,
  output logic [1:0] vlevel
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [SYNC_LEN:0] scl_p, sda_p;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       rnw, mack, thr_r;

  wire scl_now = scl_p[SYNC_LEN-1];
  wire scl_old = scl_p[SYNC_LEN];
  wire sda_now = sda_p[SYNC_LEN-1];
  wire sda_old = sda_p[SYNC_LEN];
  wire rise_c  = scl_now & ~scl_old;
  wire fall_c  = ~scl_now & scl_old;
  wire start_c = scl_now & scl_old & sda_old & ~sda_now;
  wire stop_c  = scl_now & scl_old & ~sda_old & sda_now;
  wire [7:0] rd_byte = {3'b000, stat_flags};

  assign thr_eff = thr_r | tx_thr_pin;
  assign vlevel  = sw_vsel    ? {v_top, v_bot} :
                   sel_hi_pin ? {1'b1, v_top}  : {1'b0, v_bot};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1; sda_p <= '1;
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      rnw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      out_en <= 1'b0; v_top <= 1'b0; v_bot <= 1'b0;
      tone_en <= 1'b0; mod_sel <= 1'b0; thr_r <= 1'b0;
      dyn_lim <= 1'b0; sw_vsel <= 1'b0; i_sel <= '0;
    end else begin
      scl_p <= {scl_p[SYNC_LEN-1:0], scl_i};
      sda_p <= {sda_p[SYNC_LEN-1:0], sda_i};
      if (!pwr_good) begin
        st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (rise_c && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_now};
              cnt <= cnt + 4'd1;
            end else if (fall_c && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sh[7:1] == {DEV_HI, addr_sel}) begin
                  sda_oe <= 1'b1; rnw <= sh[0]; st <= S_AACK;
                end else st <= S_IDLE;
              end else begin
                sda_oe <= 1'b1; st <= S_WACK;
                case (sh[7:5])
                  3'b001: begin tone_en <= sh[4]; mod_sel <= sh[3]; thr_r <= sh[2]; end
                  3'b010: begin dyn_lim <= sh[4]; sw_vsel <= sh[3]; i_sel <= sh[1:0]; end
                  3'b011: begin out_en <= sh[4]; v_top <= sh[1]; v_bot <= sh[0]; end
                  default: ;
                endcase
              end
            end
          end
          S_AACK: if (fall_c) begin
            if (rnw) begin
              tx <= rd_byte; sda_oe <= ~rd_byte[7]; st <= S_RD;
            end else begin
              sda_oe <= 1'b0; st <= S_WR;
            end
          end
          S_WACK: if (fall_c) begin
            sda_oe <= 1'b0; st <= S_WR;
          end
          S_RD: if (fall_c) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; cnt <= '0; st <= S_RACK;
            end else begin
              tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; cnt <= cnt + 4'd1;
            end
          end
          S_RACK: begin
            if (rise_c) mack <= ~sda_now;
            if (fall_c) begin
              if (mack) begin
                tx <= rd_byte; sda_oe <= ~rd_byte[7]; st <= S_RD;
              end else st <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
      if (!pwr_good || stat_flags[4]) begin
        out_en <= 1'b0; v_top <= 1'b0; v_bot <= 1'b0;
        tone_en <= 1'b0; mod_sel <= 1'b0; thr_r <= 1'b0;
        dyn_lim <= 1'b0; sw_vsel <= 1'b0; i_sel <= '0;
      end
    end
  end
endmodule

// File: rtl/lnb_ctrl_i2c_slave_chk.sv
`timescale 1ns/1ps
module lnb_ctrl_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       scl_i,
  input logic [4:0] stat_flags,
  input logic       sda_oe,
  input logic       out_en,
  input logic       v_top,
  input logic       v_bot,
  input logic       tone_en,
  input logic       mod_sel,
  input logic       dyn_lim,
  input logic       sw_vsel,
  input logic [1:0] i_sel
);
  wire regs_zero = !(out_en | v_top | v_bot | tone_en | mod_sel |
                     dyn_lim | sw_vsel | (|i_sel));

  p_no_ack_unpowered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !sda_oe);

  p_cleared_unpowered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> regs_zero);

  p_otemp_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_flags[4] |=> regs_zero);

  p_drive_while_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  p_reset_zero_r13: assert property (@(posedge clk)
    !rst_n |-> (regs_zero && !sda_oe));
endmodule

bind lnb_ctrl_i2c_slave lnb_ctrl_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .scl_i(scl_i),
  .stat_flags(stat_flags), .sda_oe(sda_oe), .out_en(out_en),
  .v_top(v_top), .v_bot(v_bot), .tone_en(tone_en), .mod_sel(mod_sel),
  .dyn_lim(dyn_lim), .sw_vsel(sw_vsel), .i_sel(i_sel)
);

// File: tb/test_lnb_ctrl_i2c_slave.sv
`timescale 1ns/1ps
module test_lnb_ctrl_i2c_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b1, scl_m = 1'b1, sda_m = 1'b1, pwr_good = 1'b1;
  logic tx_thr_pin = 1'b0, sel_hi_pin = 1'b0;
  logic [1:0] addr_sel = 2'b10;
  logic [4:0] flags = '0;
  logic sda_oe, out_en, v_top, v_bot, tone_en, mod_sel, thr_eff, dyn_lim, sw_vsel;
  logic [1:0] i_sel, vlevel;
  wire sda_line = sda_m & ~sda_oe;

  lnb_ctrl_i2c_slave i_lnb_ctrl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .pwr_good(pwr_good), .stat_flags(flags),
    .tx_thr_pin(tx_thr_pin), .sel_hi_pin(sel_hi_pin),
    .out_en(out_en), .v_top(v_top), .v_bot(v_bot), .tone_en(tone_en),
    .mod_sel(mod_sel), .thr_eff(thr_eff), .dyn_lim(dyn_lim), .sw_vsel(sw_vsel),
    .i_sel(i_sel), .vlevel(vlevel));

  int compared = 0, mismatched = 0;
  logic e_en = 0, e_vt = 0, e_vb = 0, e_tone = 0, e_msel = 0, e_thr = 0;
  logic e_dyn = 0, e_sw = 0, e_oe = 0;
  logic [1:0] e_isel = '0;
  logic pend = 0;
  logic [7:0] pend_byte = '0;

  function automatic logic [1:0] model_level();
    int tenths;
    if (e_sw || sel_hi_pin == 1'b0 && !e_sw)
      tenths = 0;
    if (e_sw)            tenths = e_vt ? (e_vb ? 193 : 183) : (e_vb ? 143 : 133);
    else if (sel_hi_pin) tenths = e_vt ? 193 : 183;
    else                 tenths = e_vb ? 143 : 133;
    case (tenths)
      133: return 2'd0;
      143: return 2'd1;
      183: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  always @(negedge clk) begin
    logic [12:0] act, exp;
    act = {sda_oe, out_en, v_top, v_bot, tone_en, mod_sel, thr_eff, dyn_lim, sw_vsel, i_sel, vlevel};
    exp = {e_oe, e_en, e_vt, e_vb, e_tone, e_msel, e_thr | tx_thr_pin, e_dyn, e_sw, e_isel, model_level()};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL per-cycle R3 R4 R5 R11 R12 t=%0t actual=%b expected=%b", $time, act, exp);
    end
  end

  task automatic clear_exp();
    e_en = 0; e_vt = 0; e_vb = 0; e_tone = 0; e_msel = 0; e_thr = 0;
    e_dyn = 0; e_sw = 0; e_isel = '0;
  endtask

  task automatic apply_write(input logic [7:0] b);
    if (!pwr_good || flags[4]) return;
    case (b[7:5])
      3'd1: begin e_tone = b[4]; e_msel = b[3]; e_thr = b[2]; end
      3'd2: begin e_dyn = b[4]; e_sw = b[3]; e_isel = b[1:0]; end
      3'd3: begin e_en = b[4]; e_vt = b[1]; e_vb = b[0]; end
      default: ;
    endcase
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic scl_lo(input logic oe_after);
    scl_m = 1'b0;
    tick(3);
    e_oe = oe_after;
    if (pend) begin apply_write(pend_byte); pend = 1'b0; end
    tick(Q - 3);
  endtask

  task automatic start_c();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_lo(1'b0);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack,
                           input logic oe_after_ack, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      if (i == 0) begin
        pend = exp_ack; pend_byte = b;
        scl_lo(exp_ack);
      end else scl_lo(1'b0);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    chk(tag, int'(!sda_line), int'(exp_ack));
    tick(Q);
    scl_lo(exp_ack ? oe_after_ack : 1'b0);
  endtask

  task automatic recv_byte(input logic [7:0] exp_b, input logic master_ack, input string tag);
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] shl;
      shl = exp_b << (8 - i);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      chk(tag, int'(sda_line), int'(exp_b[i]));
      tick(Q);
      scl_lo(i == 0 ? 1'b0 : !shl[7]);
    end
    sda_m = !master_ack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_lo(master_ack ? 1'b1 : 1'b0);
    sda_m = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    tick(10);
    chk("R13 reset sda_oe", int'(sda_oe), 0);
    chk("R13 reset outputs", int'({out_en, v_top, v_bot, tone_en, mod_sel, dyn_lim, sw_vsel, i_sel}), 0);
    rst_n = 1'b1; tick(4);

    // R2 R3 R4 R5 R7: one transfer, three registers (address 0x14 write)
    start_c();
    send_byte(8'h14, 1'b1, 1'b0, "R1 address ack");
    send_byte(8'h34, 1'b1, 1'b0, "R3 tone byte ack");
    send_byte(8'h52, 1'b1, 1'b0, "R4 command byte ack");
    send_byte(8'h72, 1'b1, 1'b0, "R7 control byte ack");
    stop_c();
    chk("R3 tone_en", int'(tone_en), 1);
    chk("R4 i_sel", int'(i_sel), 2);
    chk("R5 out_en", int'(out_en), 1);

    // R11 pin-controlled range
    sel_hi_pin = 1'b1; tick(4);
    chk("R11 pin high uses top", int'(vlevel), 3);
    sel_hi_pin = 1'b0; tick(4);
    chk("R11 pin low uses bottom", int'(vlevel), 0);

    // R11 register-only selection
    start_c();
    send_byte(8'h14, 1'b1, 1'b0, "R1 address ack");
    send_byte(8'h49, 1'b1, 1'b0, "R4 command byte ack");
    send_byte(8'h61, 1'b1, 1'b0, "R5 control byte ack");
    stop_c();
    chk("R11 sw select level", int'(vlevel), 1);
    sel_hi_pin = 1'b1; tick(4);
    chk("R11 pin ignored in sw mode", int'(vlevel), 1);
    sel_hi_pin = 1'b0;

    // R1 foreign address
    start_c();
    send_byte(8'h16, 1'b0, 1'b0, "R1 foreign address nack");
    send_byte(8'h7F, 1'b0, 1'b0, "R1 data after nack");
    stop_c();
    chk("R1 foreign address no change", int'({out_en, v_bot}), 1);

    // R6 status and 1xx selects ignored
    start_c();
    send_byte(8'h14, 1'b1, 1'b0, "R1 address ack");
    send_byte(8'h1F, 1'b1, 1'b0, "R6 status select ack");
    send_byte(8'h9F, 1'b1, 1'b0, "R6 1xx select ack");
    send_byte(8'hFF, 1'b1, 1'b0, "R6 1xx select ack");
    stop_c();
    chk("R6 ignored selects", int'({dyn_lim, sw_vsel, i_sel, out_en, v_top, v_bot}), 7'b0101001);

    // R12 threshold OR
    start_c();
    send_byte(8'h14, 1'b1, 1'b0, "R1 address ack");
    send_byte(8'h20, 1'b1, 1'b0, "R3 tone clear ack");
    stop_c();
    chk("R12 thr low", int'(thr_eff), 0);
    tx_thr_pin = 1'b1; tick(2);
    chk("R12 thr from pin", int'(thr_eff), 1);
    tx_thr_pin = 1'b0; tick(2);

    // R8 read with ACK then NACK
    flags = 5'b01011; tick(2);
    start_c();
    send_byte(8'h15, 1'b1, 1'b1, "R8 read address ack");
    recv_byte(8'h0B, 1'b1, "R8 first status bit");
    recv_byte(8'h0B, 1'b0, "R8 repeated status bit");
    chk("R8 released after nack", int'(sda_oe), 0);
    stop_c();
    flags = 5'b00000; tick(2);

    // R1 other address pin setting
    addr_sel = 2'b00; tick(2);
    start_c();
    send_byte(8'h10, 1'b1, 1'b0, "R1 address 0x08 ack");
    send_byte(8'h73, 1'b1, 1'b0, "R5 control byte ack");
    stop_c();
    chk("R5 control fields", int'({out_en, v_top, v_bot}), 7);

    // R10 over-temperature clears and blocks writes
    flags = 5'b10000; tick(1); clear_exp(); tick(3);
    chk("R10 cleared", int'({out_en, v_top, v_bot, sw_vsel, i_sel}), 0);
    start_c();
    send_byte(8'h10, 1'b1, 1'b0, "R10 address ack");
    send_byte(8'h73, 1'b1, 1'b0, "R10 write ack");
    stop_c();
    chk("R10 write blocked", int'(out_en), 0);
    flags = 5'b00000; tick(2);

    // R9 power-good loss
    start_c();
    send_byte(8'h10, 1'b1, 1'b0, "R1 address ack");
    send_byte(8'h3C, 1'b1, 1'b0, "R3 tone byte ack");
    stop_c();
    chk("R3 mod_sel", int'(mod_sel), 1);
    pwr_good = 1'b0; tick(1); clear_exp(); tick(3);
    chk("R9 cleared", int'({tone_en, mod_sel}), 0);
    start_c();
    send_byte(8'h10, 1'b0, 1'b0, "R9 no ack unpowered");
    stop_c();
    pwr_good = 1'b1; tick(4);
    start_c();
    send_byte(8'h10, 1'b1, 1'b0, "R9 ack after power back");
    send_byte(8'h30, 1'b1, 1'b0, "R3 tone byte ack");
    stop_c();
    chk("R9 writable again", int'(tone_en), 1);

    tick(10);
    summary();
    $finish;
  end
endmodule